// File: doc/BRIEF.md
# Four-Channel Hysteretic Signal Detector

This block watches four receive lanes and raises a per-lane detect flag when a digitised peak-to-peak amplitude, given in millivolts, shows that a real signal is present. Every lane has two 2-bit codes: one picks the level that sets the flag and one picks the level that clears it. The codes are looked up in two small threshold tables. Neither table is ordered by code value. A flag set by a large amplitude stays set through the gap between the two levels, so noise near one level does not make the flag toggle.

The four flags come out as a packed status nibble. The flags also feed two lane controls. The first is a lane enable: it follows either an external enable pin or, in auto-enable mode, the lane's own flag, so a lane with no input goes to standby. The second is a squelch mute that silences lanes with no signal. A disable input turns the squelch off. The amplitude front end and the analog mute stage are outside this block. Two configuration bytes hold the codes. Each byte has its own write strobe and its own read-back port.

Top module: `sigdet_quad_top`

## Requirements
- R1: After reset every detect flag is 0 and both configuration bytes read 0x00.
- R2: Set-level code decode: 00 = 130 mV, 01 = 125 mV, 10 = 150 mV, 11 = 140 mV.
- R3: Clear-level code decode: 00 = 60 mV, 01 = 40 mV, 10 = 105 mV, 11 = 90 mV.
- R4: On a sample strobe, a flag becomes 1 when the amplitude is strictly greater than its set level. It becomes 0 when the amplitude is strictly less than its clear level. In all other cases, including equality with either level, it keeps its value. The new flag appears at the port in the cycle after the strobe edge.
- R5: In each configuration byte, lane n's code sits in bits 2n+1:2n, so lane 3 uses bits 7:6 and lane 0 uses bits 1:0.
- R6: A lane's flag changes only on a clock edge where that lane's own strobe bit is 1. Strobes of other lanes and amplitudes without a strobe have no effect on it.
- R7: If the clear level selected for a lane is not below its set level, a strobe leaves that lane's flag unchanged.
- R8: With auto-enable at 1, each lane enable equals that lane's flag. With auto-enable at 0, each lane enable equals the matching enable pin.
- R9: With squelch-disable at 0, a lane is muted exactly when its flag is 0. With squelch-disable at 1, no lane is muted.
- R10: Status bit n carries lane n's detect flag.
- R11: A configuration write takes effect at the clock edge where its strobe is seen. A strobe sampled at the same edge still uses the old codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| amp_vld_i | input | 4 | Per-lane sample strobe |
| amp_i | input | 48 | Lane n amplitude in mV at bits 12n+11:12n |
| on_we_i | input | 1 | Write strobe for the set-level code byte |
| off_we_i | input | 1 | Write strobe for the clear-level code byte |
| cfg_wdata_i | input | 8 | Code byte to write |
| on_cfg_o | output | 8 | Set-level code byte read-back |
| off_cfg_o | output | 8 | Clear-level code byte read-back |
| auto_en_i | input | 1 | 1: lane enables follow the detect flags |
| en_pin_i | input | 4 | External lane enables, used when auto-enable is 0 |
| oob_dis_i | input | 1 | 1: squelch muting switched off |
| det_o | output | 4 | Detect status nibble, bit n is lane n |
| ch_en_o | output | 4 | Lane enables |
| mute_o | output | 4 | Lane squelch mutes |

## Verification
The assertions assume that amplitudes and strobes are stable across each clock edge. They also assume that the configuration bytes are not written during the cycles in which the internal reset is still being released. The stimulus is driven only on falling edges, and every write is issued after the reset-release settling cycles. The random amplitudes are weighted to land on each selected level and one step either side of it, so the strict comparisons are tested exactly at their edges. The tables of the second instance create lanes whose clear level is above their set level, so the hold rule for that case is exercised.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;
  localparam int CODE_W = 2;
  localparam int NCODE  = 1 << CODE_W;

  typedef enum logic [1:0] {
    HYS_HOLD = 2'd0,
    HYS_SET  = 2'd1,
    HYS_CLR  = 2'd2
  } hys_act_e;
endpackage

// File: rtl/sigdet_rst_sync.sv
module sigdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sigdet_cfg_reg.sv
module sigdet_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (we_i) q_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R11: a write lands on the edge where it is sampled
  p_write_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));
  // R11: without a write the byte keeps its value
  p_no_write_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/sigdet_chan.sv
module sigdet_chan
  import sigdet_pkg::*;
#(
  parameter int                       AMP_W  = 12,
  parameter logic [NCODE*AMP_W-1:0]   ON_TBL  = '0,
  parameter logic [NCODE*AMP_W-1:0]   OFF_TBL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [AMP_W-1:0]  amp_i,
  input  logic [CODE_W-1:0] on_code_i,
  input  logic [CODE_W-1:0] off_code_i,
  output logic              det_o
);
  logic [AMP_W-1:0] on_thr, off_thr;
  logic             inverted;
  hys_act_e         act;
  logic             det_q, det_d;

  // threshold lookup
  always_comb begin
    on_thr  = ON_TBL[int'(on_code_i)*AMP_W +: AMP_W];
    off_thr = OFF_TBL[int'(off_code_i)*AMP_W +: AMP_W];
    inverted = (off_thr >= on_thr);
  end

  // hysteresis decision
  always_comb begin
    act = HYS_HOLD;
    if (vld_i && !inverted) begin
      if (amp_i > on_thr)       act = HYS_SET;
      else if (amp_i < off_thr) act = HYS_CLR;
    end
  end

  always_comb begin
    case (act)
      HYS_SET: det_d = 1'b1;
      HYS_CLR: det_d = 1'b0;
      default: det_d = det_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) det_q <= 1'b0;
    else         det_q <= det_d;
  end

  assign det_o = det_q;

  // R4: above the set level raises the flag
  p_rise_above_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (off_thr < on_thr) && (amp_i > on_thr)) |=> det_o);
  // R4: below the clear level drops the flag
  p_fall_below_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (off_thr < on_thr) && (amp_i < off_thr)) |=> !det_o);
  // R4: inside the band the flag holds
  p_band_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (amp_i <= on_thr) && (amp_i >= off_thr)) |=> $stable(det_o));
  // R6: no strobe, no change
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(det_o));
  // R7: crossed levels freeze the flag
  p_crossed_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (off_thr >= on_thr)) |=> $stable(det_o));
endmodule

// File: rtl/sigdet_lane_ctl.sv
module sigdet_lane_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] det_i,
  input  logic           auto_en_i,
  input  logic [NCH-1:0] en_pin_i,
  input  logic           oob_dis_i,
  output logic [NCH-1:0] ch_en_o,
  output logic [NCH-1:0] mute_o
);
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_en_o[i] = auto_en_i ? det_i[i] : en_pin_i[i];
      mute_o[i]  = !oob_dis_i && !det_i[i];
    end
  end

  // R8: auto mode ties enable to the flag
  p_auto_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i |-> (ch_en_o == det_i));
  // R9: squelch off means no lane muted
  p_squelch_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oob_dis_i |-> (mute_o == '0));
  // R9: a lane with a signal is never muted
  p_live_unmuted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o & det_i) == '0);
  // R9: squelch on, every lane is live or muted
  p_quiet_muted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oob_dis_i |-> ((mute_o | det_i) == '1));
endmodule

// File: rtl/sigdet_quad_top.sv
module sigdet_quad_top
  import sigdet_pkg::*;
#(
  parameter int                     NCH     = 4,
  parameter int                     AMP_W   = 12,
  parameter logic [NCODE*AMP_W-1:0] ON_TBL  = {AMP_W'(140), AMP_W'(150), AMP_W'(125), AMP_W'(130)},
  parameter logic [NCODE*AMP_W-1:0] OFF_TBL = {AMP_W'(90),  AMP_W'(105), AMP_W'(40),  AMP_W'(60)},
  localparam int                    CFG_W   = NCH*CODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       amp_vld_i,
  input  logic [NCH*AMP_W-1:0] amp_i,
  input  logic                 on_we_i,
  input  logic                 off_we_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  output logic [CFG_W-1:0]     on_cfg_o,
  output logic [CFG_W-1:0]     off_cfg_o,
  input  logic                 auto_en_i,
  input  logic [NCH-1:0]       en_pin_i,
  input  logic                 oob_dis_i,
  output logic [NCH-1:0]       det_o,
  output logic [NCH-1:0]       ch_en_o,
  output logic [NCH-1:0]       mute_o
);
  logic           rst_n;
  logic [NCH-1:0] det;

  sigdet_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  sigdet_cfg_reg #(.W(CFG_W)) u_on_cfg (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(on_we_i),
    .wdata_i(cfg_wdata_i), .q_o(on_cfg_o)
  );

  sigdet_cfg_reg #(.W(CFG_W)) u_off_cfg (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(off_we_i),
    .wdata_i(cfg_wdata_i), .q_o(off_cfg_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    sigdet_chan #(
      .AMP_W(AMP_W), .ON_TBL(ON_TBL), .OFF_TBL(OFF_TBL)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .vld_i      (amp_vld_i[g]),
      .amp_i      (amp_i[g*AMP_W +: AMP_W]),
      .on_code_i  (on_cfg_o[g*CODE_W +: CODE_W]),
      .off_code_i (off_cfg_o[g*CODE_W +: CODE_W]),
      .det_o      (det[g])
    );
  end

  sigdet_lane_ctl #(.NCH(NCH)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_n), .det_i(det),
    .auto_en_i(auto_en_i), .en_pin_i(en_pin_i), .oob_dis_i(oob_dis_i),
    .ch_en_o(ch_en_o), .mute_o(mute_o)
  );

  assign det_o = det;

  // R1: flags are low while the internal reset is held
  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_n |=> (det_o == '0) || rst_n);
endmodule

// File: tb/tb_sigdet_quad_top.sv
`timescale 1ns/1ps
module tb_sigdet_quad_top;
  localparam int NCH = 4;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    vld = '0;
  logic [47:0]   amp = '0;
  logic          on_we = 1'b0, off_we = 1'b0;
  logic [7:0]    wdata = '0;
  logic          auto_en = 1'b0;
  logic [3:0]    en_pin = '0;
  logic          oob_dis = 1'b0;

  logic [7:0] on_cfg, off_cfg, on_cfg_x, off_cfg_x;
  logic [3:0] det, ch_en, mute, det_x, ch_en_x, mute_x;

  int checks = 0;
  int fails  = 0;

  bit [3:0] m_det = '0, m_xdet = '0;
  bit [7:0] m_on = '0, m_off = '0;

  always #2 clk = ~clk;

  sigdet_quad_top dut (
    .clk_i(clk), .rst_ni(rst_n), .amp_vld_i(vld), .amp_i(amp),
    .on_we_i(on_we), .off_we_i(off_we), .cfg_wdata_i(wdata),
    .on_cfg_o(on_cfg), .off_cfg_o(off_cfg), .auto_en_i(auto_en),
    .en_pin_i(en_pin), .oob_dis_i(oob_dis), .det_o(det),
    .ch_en_o(ch_en), .mute_o(mute)
  );

  // second copy: code 10 gives a clear level above the set level
  sigdet_quad_top #(
    .ON_TBL ({12'd140, 12'd50,  12'd125, 12'd130}),
    .OFF_TBL({12'd90,  12'd100, 12'd40,  12'd60})
  ) dut_x (
    .clk_i(clk), .rst_ni(rst_n), .amp_vld_i(vld), .amp_i(amp),
    .on_we_i(on_we), .off_we_i(off_we), .cfg_wdata_i(wdata),
    .on_cfg_o(on_cfg_x), .off_cfg_o(off_cfg_x), .auto_en_i(auto_en),
    .en_pin_i(en_pin), .oob_dis_i(oob_dis), .det_o(det_x),
    .ch_en_o(ch_en_x), .mute_o(mute_x)
  );

  function automatic int lvl(bit xtbl, bit set_lvl, bit [1:0] code);
    if (set_lvl) begin
      case (code)
        2'b00: return 130;
        2'b01: return 125;
        2'b10: return xtbl ? 50 : 150;
        default: return 140;
      endcase
    end else begin
      case (code)
        2'b00: return 60;
        2'b01: return 40;
        2'b10: return xtbl ? 100 : 105;
        default: return 90;
      endcase
    end
  endfunction

  function automatic bit nxt(bit xtbl, bit cur, bit v, int a, bit [1:0] oc, bit [1:0] fc);
    int hi = lvl(xtbl, 1'b1, oc);
    int lo = lvl(xtbl, 1'b0, fc);
    if (!v || lo >= hi) return cur;
    if (a > hi) return 1'b1;
    if (a < lo) return 1'b0;
    return cur;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " (det R4 R10)"}, {4'h0, det}, {4'h0, m_det});
    chk("R7 crossed-level copy det", {4'h0, det_x}, {4'h0, m_xdet});
    chk("R8 lane enable", {4'h0, ch_en}, {4'h0, auto_en ? m_det : en_pin});
    chk("R9 mute", {4'h0, mute}, {4'h0, oob_dis ? 4'h0 : ~m_det});
    chk("R5 R11 set-level byte", on_cfg, m_on);
    chk("R5 R11 clear-level byte", off_cfg, m_off);
  endtask

  // inputs are set before the call; the edge is taken inside
  task automatic step(input string tag);
    bit [3:0] nd, nx;
    for (int c = 0; c < NCH; c++) begin
      int a = int'(amp[c*AW +: AW]);
      nd[c] = nxt(1'b0, m_det[c],  vld[c], a, m_on[2*c +: 2], m_off[2*c +: 2]);
      nx[c] = nxt(1'b1, m_xdet[c], vld[c], a, m_on[2*c +: 2], m_off[2*c +: 2]);
    end
    @(negedge clk);
    m_det  = nd;
    m_xdet = nx;
    if (on_we)  m_on  = wdata;
    if (off_we) m_off = wdata;
    compare(tag);
  endtask

  task automatic amp_all(input int a, input logic [3:0] v);
    for (int c = 0; c < NCH; c++) amp[c*AW +: AW] = AW'(a);
    vld = v;
  endtask

  task automatic wr(input bit set_byte, input logic [7:0] d, input string tag);
    vld = '0; wdata = d; on_we = set_byte; off_we = !set_byte;
    step(tag);
    on_we = 1'b0; off_we = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step("R1 idle after reset");
    // R1: reset state
    chk("R1 det after reset", {4'h0, det}, 8'h00);
    chk("R1 set byte after reset", on_cfg, 8'h00);
    chk("R1 clear byte after reset", off_cfg, 8'h00);

    // R4 R2: equality with the set level holds low, one above sets
    amp_all(130, 4'hf); step("R4 equal to set level");
    amp_all(131, 4'hf); step("R2 R4 above 130");
    amp_all(60, 4'hf);  step("R4 equal to clear level");
    amp_all(59, 4'hf);  step("R3 R4 below 60");
    // R6: no strobe / single strobe
    amp_all(200, 4'h0); step("R6 no strobe");
    amp_all(200, 4'h1); step("R6 R10 lane 0 strobe only");
    // R5 R2: per-lane set codes
    wr(1'b1, 8'b11_10_01_00, "R11 set byte write");
    amp_all(145, 4'hf); step("R2 R5 R10 mixed set codes");
    wr(1'b0, 8'b00_01_10_11, "R11 clear byte write");
    amp_all(95, 4'hf);  step("R3 R5 mixed clear codes");
    // R11: write and strobe on the same edge use old codes
    amp_all(141, 4'hf); wdata = 8'h00; on_we = 1'b1;
    step("R11 same-edge write");
    on_we = 1'b0;
    // R8 R9: control modes
    auto_en = 1'b1; en_pin = 4'b0101; amp_all(0, 4'h0); step("R8 auto enable");
    auto_en = 1'b0; step("R8 pin enable");
    oob_dis = 1'b1; step("R9 squelch off");
    oob_dis = 1'b0; step("R9 squelch on");
    // R7: crossed levels on the second copy
    wr(1'b1, 8'h00, "R7 setup"); wr(1'b0, 8'h00, "R7 setup");
    amp_all(200, 4'hf); step("R7 both set");
    wr(1'b1, 8'haa, "R7 crossed codes"); wr(1'b0, 8'haa, "R7 crossed codes");
    amp_all(0, 4'hf);   step("R7 low amplitude holds");
    amp_all(200, 4'hf); step("R7 high amplitude");
    wr(1'b1, 8'h00, "R7 normal codes"); wr(1'b0, 8'h00, "R7 normal codes");
    amp_all(0, 4'hf);   step("R7 cleared");
    wr(1'b1, 8'haa, "R7 crossed again"); wr(1'b0, 8'haa, "R7 crossed again");
    amp_all(200, 4'hf); step("R7 high amplitude holds low");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      vld = 4'($urandom_range(0, 15));
      for (int c = 0; c < NCH; c++) begin
        int base;
        case ($urandom_range(0, 3))
          0: base = lvl(1'b0, 1'b1, m_on[2*c +: 2]);
          1: base = lvl(1'b0, 1'b0, m_off[2*c +: 2]);
          default: base = int'($urandom_range(1, 254));
        endcase
        amp[c*AW +: AW] = AW'(base + int'($urandom_range(0, 2)) - 1);
      end
      on_we  = ($urandom_range(0, 19) == 0);
      off_we = ($urandom_range(0, 19) == 0);
      wdata  = 8'($urandom_range(0, 255));
      auto_en = 1'($urandom_range(0, 1));
      en_pin  = 4'($urandom_range(0, 15));
      oob_dis = 1'($urandom_range(0, 1));
      step("R2 R3 R4 R5 R6 R8 R9 R10 R11 random");
    end
    on_we = 1'b0; off_we = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule